// File: doc/BRIEF.md
# Console Memory Bus Address Decoder

This block sits between an 8-bit processor core and the storage of a small handheld-style console. It takes one byte-wide request per clock on a 16-bit address bus and sends it to one target. The internal targets are a video RAM, a work RAM (which also appears in an echo window), a small high RAM and an interrupt-enable byte. The external targets are a cartridge read port, a boot ROM read port and an I/O register port. An access to an address with nothing behind it, and any write into the read-only cartridge half of the map, raises an error pulse. Such an access never completes silently.

After reset the first 256 bytes of the map are served by the boot ROM instead of the cartridge. A single write to a fixed control address turns this overlay off, and only a reset turns it back on. Read results come back one clock after the request. The internal RAM depths are parameters. When a depth is smaller than its 8 KiB window, the window repeats modulo that depth. Setting the address width to 13 gives a fully decoded window.

Top module: `memBusDecoder`

## Requirements
- R1: Reads of 0x0000–0x7FFF, outside the boot overlay, return `cartData` for `cartAddr` = address bits [14:0]. Any write to 0x0000–0x7FFF raises `accErr` and changes nothing.
- R2: From reset, while the overlay is active, reads of 0x0000–0x00FF return `bootData` for `bootAddr` = address bits [7:0]. Address 0x0100 and above still read the cartridge.
- R3: A write of any data to 0xFF50 turns the overlay off until the next reset. This write is not forwarded to the I/O port and raises no error.
- R4: 0x8000–0x9FFF is a read/write video RAM indexed by the low VRAM_ADDR_BITS address bits, so the window repeats modulo its depth.
- R5: 0xC000–0xDFFF is a read/write work RAM indexed by the low WRAM_ADDR_BITS address bits.
- R6: 0xE000–0xFDFF is an echo of the work RAM. A byte written through either window reads back through the other at the same offset.
- R7: 0xFF80–0xFFFE is a 127-byte read/write high RAM.
- R8: 0xFFFF is an 8-bit interrupt-enable register that resets to 0x00 and reads back the last byte written to it.
- R9: 0xFF00–0xFF7F is forwarded to the I/O port in the request cycle: `ioAddr` = address bits [6:0], `ioWrData` = write data, and `ioWe` or `ioRe` high. On a read, `ioRdData` is captured at that clock edge.
- R10: 0xA000–0xBFFF and 0xFE00–0xFEFF are unmapped. A read or write there raises `accErr`, and a read there returns 0x00.
- R11: `rdData` is valid one clock after a read request and holds its value until the next read. `accErr` is high only in the cycle after an illegal request.
- R12: While reset is held and just after it, `rdData` is 0x00 and `accErr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqAddr | input | 16 | Request address |
| reqWrData | input | 8 | Write data |
| reqWe | input | 1 | Write request |
| reqRe | input | 1 | Read request |
| rdData | output | 8 | Read result, one clock after the request |
| accErr | output | 1 | Illegal-access pulse, one clock after the request |
| cartAddr | output | 15 | Cartridge read address |
| cartData | input | 8 | Cartridge read data |
| bootAddr | output | 8 | Boot ROM read address |
| bootData | input | 8 | Boot ROM read data |
| ioAddr | output | 7 | I/O register offset |
| ioWrData | output | 8 | I/O write data |
| ioWe | output | 1 | I/O write strobe |
| ioRe | output | 1 | I/O read strobe |
| ioRdData | input | 8 | I/O read data |

## Verification
The assertions check four properties on every cycle:
- a cartridge write always produces an error pulse;
- an error pulse always follows a request;
- the overlay flag never comes back on without a reset;
- the I/O strobes fire only inside their window, and `rdData` does not move unless a read came first.

Only the bench's scenarios can show that the data is right. The bench sweeps every RAM window and its aliases, and reads the boot bytes before and after the overlay is switched off. It also checks that the interrupt-enable byte and the echo window agree with a model computed arithmetically in the bench.

// File: rtl/memBusPkg.sv
package memBusPkg;

  localparam int BOOT_SPAN = 256;

  typedef enum logic [2:0] {
    RG_NONE, RG_CART, RG_BOOT, RG_VRAM, RG_WRAM, RG_IO, RG_HRAM, RG_IE
  } region_e;

  typedef enum logic [1:0] {
    SRC_EXT, SRC_VRAM, SRC_WRAM, SRC_HRAM
  } rdSrc_e;

  typedef struct packed {
    logic    vramWe;
    logic    vramRe;
    logic    wramWe;
    logic    wramRe;
    logic    hramWe;
    logic    hramRe;
    logic    ieWe;
    logic    extLoad;
    region_e extRegion;
    rdSrc_e  outSrc;
  } strobe_t;

endpackage

// File: rtl/memBusRam.sv
module memBusRam #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wd,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  // read-before-write; output register only moves on a read
  always_ff @(posedge clk) begin
    if (!rstN)   q <= '0;
    else if (re) q <= mem[addr];
  end
endmodule

// File: rtl/memBusCtrl.sv
module memBusCtrl
  import memBusPkg::*;
#(
  parameter logic [15:0] BOOT_OFF_ADDR = 16'hFF50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] reqAddr,
  input  logic        reqWe,
  input  logic        reqRe,
  output strobe_t     stb,
  output logic        accErr,
  output logic        ioWe,
  output logic        ioRe
);
  localparam logic [15:0] BOOT_TOP = 16'(BOOT_SPAN);

  region_e region;
  rdSrc_e  srcNext;
  rdSrc_e  outSrcQ;
  logic    bootOn;
  logic    isBootOff;
  logic    badReq;

  always_comb begin
    if (!reqAddr[15])                region = (bootOn && reqAddr < BOOT_TOP) ? RG_BOOT : RG_CART;
    else if (reqAddr < 16'hA000)     region = RG_VRAM;
    else if (reqAddr < 16'hC000)     region = RG_NONE;
    else if (reqAddr < 16'hFE00)     region = RG_WRAM;
    else if (reqAddr < 16'hFF00)     region = RG_NONE;
    else if (reqAddr < 16'hFF80)     region = RG_IO;
    else if (reqAddr != 16'hFFFF)    region = RG_HRAM;
    else                             region = RG_IE;
  end

  assign isBootOff = (reqAddr == BOOT_OFF_ADDR);

  always_comb begin
    badReq = 1'b0;
    if (reqWe && (region == RG_CART || region == RG_BOOT)) badReq = 1'b1;
    if ((reqWe || reqRe) && region == RG_NONE)             badReq = 1'b1;
  end

  always_comb begin
    case (region)
      RG_VRAM: srcNext = SRC_VRAM;
      RG_WRAM: srcNext = SRC_WRAM;
      RG_HRAM: srcNext = SRC_HRAM;
      default: srcNext = SRC_EXT;
    endcase
  end

  always_comb begin
    stb.vramWe    = reqWe && region == RG_VRAM;
    stb.vramRe    = reqRe && region == RG_VRAM;
    stb.wramWe    = reqWe && region == RG_WRAM;
    stb.wramRe    = reqRe && region == RG_WRAM;
    stb.hramWe    = reqWe && region == RG_HRAM;
    stb.hramRe    = reqRe && region == RG_HRAM;
    stb.ieWe      = reqWe && region == RG_IE;
    stb.extLoad   = reqRe && srcNext == SRC_EXT;
    stb.extRegion = region;
    stb.outSrc    = outSrcQ;
  end

  assign ioWe = reqWe && region == RG_IO && !isBootOff;
  assign ioRe = reqRe && region == RG_IO;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSrcQ <= SRC_EXT;
      accErr  <= 1'b0;
      bootOn  <= 1'b1;
    end else begin
      accErr <= badReq;
      if (reqRe)               outSrcQ <= srcNext;
      if (reqWe && isBootOff)  bootOn  <= 1'b0;
    end
  end

  assert_rom_write_err_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqWe && !reqAddr[15]) |=> accErr);

  assert_boot_stays_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(bootOn));

  assert_boot_off_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqWe && reqAddr == BOOT_OFF_ADDR) |=> !bootOn);

  assert_io_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ioWe || ioRe) |-> (reqAddr[15:7] == 9'h1FE));

  assert_err_follows_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past(reqWe || reqRe));
endmodule

// File: rtl/memBusPath.sv
module memBusPath
  import memBusPkg::*;
#(
  parameter int VAW = 11,
  parameter int WAW = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqWrData,
  input  logic [7:0]  cartData,
  input  logic [7:0]  bootData,
  input  logic [7:0]  ioRdData,
  output logic [7:0]  rdData
);
  localparam int HAW = 7;

  logic [7:0] vramQ, wramQ, hramQ, extQ, ieReg, extNext;

  memBusRam #(.AW(VAW)) uVram (
    .clk(clk), .rstN(rstN), .we(stb.vramWe), .re(stb.vramRe),
    .addr(reqAddr[VAW-1:0]), .wd(reqWrData), .q(vramQ));

  // echo window shares the low offset bits, so one index serves both
  memBusRam #(.AW(WAW)) uWram (
    .clk(clk), .rstN(rstN), .we(stb.wramWe), .re(stb.wramRe),
    .addr(reqAddr[WAW-1:0]), .wd(reqWrData), .q(wramQ));

  memBusRam #(.AW(HAW)) uHram (
    .clk(clk), .rstN(rstN), .we(stb.hramWe), .re(stb.hramRe),
    .addr(reqAddr[HAW-1:0]), .wd(reqWrData), .q(hramQ));

  always_comb begin
    case (stb.extRegion)
      RG_CART: extNext = cartData;
      RG_BOOT: extNext = bootData;
      RG_IO:   extNext = ioRdData;
      RG_IE:   extNext = ieReg;
      default: extNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieReg <= 8'h00;
      extQ  <= 8'h00;
    end else begin
      if (stb.ieWe)    ieReg <= reqWrData;
      if (stb.extLoad) extQ  <= extNext;
    end
  end

  always_comb begin
    case (stb.outSrc)
      SRC_VRAM: rdData = vramQ;
      SRC_WRAM: rdData = wramQ;
      SRC_HRAM: rdData = hramQ;
      default:  rdData = extQ;
    endcase
  end
endmodule

// File: rtl/memBusDecoder.sv
module memBusDecoder
  import memBusPkg::*;
#(
  parameter int          VRAM_ADDR_BITS = 11,
  parameter int          WRAM_ADDR_BITS = 11,
  parameter logic [15:0] BOOT_OFF_ADDR  = 16'hFF50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqWrData,
  input  logic        reqWe,
  input  logic        reqRe,
  output logic [7:0]  rdData,
  output logic        accErr,
  output logic [14:0] cartAddr,
  input  logic [7:0]  cartData,
  output logic [7:0]  bootAddr,
  input  logic [7:0]  bootData,
  output logic [6:0]  ioAddr,
  output logic [7:0]  ioWrData,
  output logic        ioWe,
  output logic        ioRe,
  input  logic [7:0]  ioRdData
);
  strobe_t stb;

  assign cartAddr = reqAddr[14:0];
  assign bootAddr = reqAddr[7:0];
  assign ioAddr   = reqAddr[6:0];
  assign ioWrData = reqWrData;

  memBusCtrl #(.BOOT_OFF_ADDR(BOOT_OFF_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWe(reqWe), .reqRe(reqRe),
    .stb(stb), .accErr(accErr), .ioWe(ioWe), .ioRe(ioRe));

  memBusPath #(.VAW(VRAM_ADDR_BITS), .WAW(WRAM_ADDR_BITS)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .cartData(cartData), .bootData(bootData), .ioRdData(ioRdData), .rdData(rdData));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqRe) |-> $stable(rdData));
endmodule

// File: tb/sim_memBusDecoder.sv
module sim_memBusDecoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWrData = '0;
  logic        reqWe = 1'b0;
  logic        reqRe = 1'b0;
  logic [7:0]  rdData, cartData, bootData, ioRdData, ioWrData;
  logic        accErr, ioWe, ioRe;
  logic [14:0] cartAddr;
  logic [7:0]  bootAddr;
  logic [6:0]  ioAddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] romPat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] bootPat(input logic [7:0] a);
    return 8'hFF ^ (a + (a << 1));
  endfunction
  function automatic logic [7:0] ioPat(input logic [6:0] a);
    return {1'b1, a} ^ 8'h33;
  endfunction

  assign cartData = romPat(cartAddr);
  assign bootData = bootPat(bootAddr);
  assign ioRdData = ioPat(ioAddr);

  memBusDecoder u0 (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .reqWe(reqWe), .reqRe(reqRe), .rdData(rdData), .accErr(accErr),
    .cartAddr(cartAddr), .cartData(cartData), .bootAddr(bootAddr), .bootData(bootData),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWe(ioWe), .ioRe(ioRe), .ioRdData(ioRdData));

  logic [7:0] vm [2048];
  logic [7:0] wm [2048];
  logic [7:0] hm [128];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] rd;
  logic       er, iow, ior;
  logic [6:0] ioa;
  logic [7:0] iowd;

  task automatic acc(input logic [15:0] a, input logic [7:0] d, input logic we, input logic re);
    @(negedge clk);
    reqAddr = a; reqWrData = d; reqWe = we; reqRe = re;
    #1;
    iow = ioWe; ior = ioRe; ioa = ioAddr; iowd = ioWrData;
    @(negedge clk);
    rd = rdData; er = accErr;
    reqWe = 1'b0; reqRe = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 rdData in reset", rdData, 8'h00);
    chk("R12 accErr in reset", accErr, 1'b0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    chk("R12 rdData after reset", rdData, 8'h00);
    chk("R12 accErr after reset", accErr, 1'b0);

    // R2 boot overlay active
    for (int i = 0; i < 256; i++) begin
      acc(16'(i), 8'h00, 1'b0, 1'b1);
      chk("R2 boot read", rd, bootPat(8'(i)));
      chk("R11 no err on legal read", er, 1'b0);
    end
    acc(16'h0100, 8'h00, 1'b0, 1'b1);
    chk("R2 first cart byte past overlay", rd, romPat(15'h0100));
    acc(16'h7FFF, 8'h00, 1'b0, 1'b1);
    chk("R1 top cart byte", rd, romPat(15'h7FFF));

    // R1 cart write is illegal
    acc(16'h1234, 8'hAA, 1'b1, 1'b0);
    chk("R1 cart write err", er, 1'b1);
    chk("R1 cart write not to io", iow, 1'b0);
    acc(16'h0010, 8'hAA, 1'b1, 1'b0);
    chk("R1 overlay write err", er, 1'b1);
    acc(16'h0010, 8'h00, 1'b0, 1'b1);
    chk("R1 overlay write no effect", rd, bootPat(8'h10));
    chk("R11 err pulse ends", er, 1'b0);

    // R8 interrupt-enable byte
    acc(16'hFFFF, 8'h00, 1'b0, 1'b1);
    chk("R8 ie reset value", rd, 8'h00);
    acc(16'hFFFF, 8'hA5, 1'b1, 1'b0);
    chk("R8 ie write no err", er, 1'b0);
    acc(16'hFFFF, 8'h00, 1'b0, 1'b1);
    chk("R8 ie readback", rd, 8'hA5);

    // R4 video RAM and its modulo alias
    for (int i = 0; i < 2048; i++) begin
      vm[i] = 8'(i) ^ 8'(i >> 8) ^ 8'hC3;
      acc(16'h8000 + 16'(i), vm[i], 1'b1, 1'b0);
    end
    for (int i = 0; i < 2048; i++) begin
      acc(16'h9800 + 16'(i), 8'h00, 1'b0, 1'b1);
      chk("R4 vram alias read", rd, vm[i]);
    end
    acc(16'h8123, 8'h00, 1'b0, 1'b1);
    chk("R4 vram direct read", rd, vm[12'h123]);

    // R5/R6 work RAM, its modulo alias and the echo window
    for (int i = 0; i < 2048; i++) begin
      wm[i] = 8'(i * 7) ^ 8'h3C;
      acc(16'hC000 + 16'(i), wm[i], 1'b1, 1'b0);
    end
    for (int i = 0; i < 2048; i++) begin
      acc(16'hE000 + 16'(i), 8'h00, 1'b0, 1'b1);
      chk("R6 echo read", rd, wm[i]);
      acc(16'hD800 + 16'(i), 8'h00, 1'b0, 1'b1);
      chk("R5 wram read", rd, wm[i]);
    end
    for (int i = 0; i < 256; i++) begin
      wm[12'h500 + i] = 8'(i) ^ 8'h81;
      acc(16'hFD00 + 16'(i), wm[12'h500 + i], 1'b1, 1'b0);
      chk("R6 echo write no err", er, 1'b0);
    end
    for (int i = 0; i < 256; i++) begin
      acc(16'hC500 + 16'(i), 8'h00, 1'b0, 1'b1);
      chk("R6 echo write seen in wram", rd, wm[12'h500 + i]);
    end

    // R7 high RAM
    for (int i = 0; i < 127; i++) begin
      hm[i] = 8'(i) ^ 8'h96;
      acc(16'hFF80 + 16'(i), hm[i], 1'b1, 1'b0);
    end
    for (int i = 0; i < 127; i++) begin
      acc(16'hFF80 + 16'(i), 8'h00, 1'b0, 1'b1);
      chk("R7 hram read", rd, hm[i]);
    end
    acc(16'hFFFF, 8'h00, 1'b0, 1'b1);
    chk("R8 ie untouched by hram", rd, 8'hA5);

    // R11 hold: a write after a read leaves rdData alone
    acc(16'hC007, 8'h00, 1'b0, 1'b1);
    chk("R11 read", rd, wm[7]);
    acc(16'h8004, 8'h11, 1'b1, 1'b0);
    chk("R11 rdData holds over write", rd, wm[7]);

    // R9 I/O forwarding
    acc(16'hFF05, 8'h3C, 1'b1, 1'b0);
    chk("R9 io write strobe", iow, 1'b1);
    chk("R9 io addr", ioa, 7'h05);
    chk("R9 io write data", iowd, 8'h3C);
    chk("R9 io write no err", er, 1'b0);
    acc(16'hFF42, 8'h00, 1'b0, 1'b1);
    chk("R9 io read strobe", ior, 1'b1);
    chk("R9 io read data", rd, ioPat(7'h42));
    acc(16'hFF80, 8'h00, 1'b0, 1'b1);
    chk("R9 no io strobe in hram", ior, 1'b0);

    // R10 unmapped
    acc(16'hA000, 8'h00, 1'b0, 1'b1);
    chk("R10 ext ram read err", er, 1'b1);
    chk("R10 ext ram read data", rd, 8'h00);
    acc(16'hBFFF, 8'h00, 1'b0, 1'b1);
    chk("R10 ext ram top err", er, 1'b1);
    acc(16'hFE00, 8'h00, 1'b0, 1'b1);
    chk("R10 sprite area err", er, 1'b1);
    chk("R10 sprite area data", rd, 8'h00);
    acc(16'hFEFF, 8'h77, 1'b1, 1'b0);
    chk("R10 unused write err", er, 1'b1);
    acc(16'hA555, 8'h77, 1'b1, 1'b0);
    chk("R10 ext ram write err", er, 1'b1);
    acc(16'hFDFF, 8'h00, 1'b0, 1'b1);
    chk("R10 echo top is mapped", er, 1'b0);
    chk("R6 echo top data", rd, wm[11'h5FF]);

    // R3 overlay off
    acc(16'hFF50, 8'h01, 1'b1, 1'b0);
    chk("R3 boot-off not forwarded", iow, 1'b0);
    chk("R3 boot-off no err", er, 1'b0);
    for (int i = 0; i < 256; i += 17) begin
      acc(16'(i), 8'h00, 1'b0, 1'b1);
      chk("R1 cart read after overlay off", rd, romPat(15'(i)));
    end
    acc(16'hFF50, 8'h00, 1'b1, 1'b0);
    acc(16'h0005, 8'h00, 1'b0, 1'b1);
    chk("R3 overlay stays off", rd, romPat(15'h0005));

    doReset();
    acc(16'h0005, 8'h00, 1'b0, 1'b1);
    chk("R3 reset restores overlay", rd, bootPat(8'h05));
    acc(16'hFFFF, 8'h00, 1'b0, 1'b1);
    chk("R8 ie cleared by reset", rd, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule